// File: doc/BRIEF.md
# Double-Edge Source-Synchronous Burst Slave Receiver

This block is the slave end of a double-edge, source-synchronous block-transfer protocol on a parallel backplane. It follows the master through three address phases that are keyed to data strobe 0 (assert, release, re-assert). In the first phase it screens the address modifier and latches the address. In the second it takes the cycle count and the rate code. In the third it decides whether to accept the transfer, flag a bus error or ask for a restart. Once it has accepted a transfer, it takes one data word on every transition of data strobe 1 and returns no per-word acknowledge. Each word goes out on a local write port at an incrementing word address, until the counted cycles run out.

Two kinds of transfer exist. A point-to-point transfer selects the slave by an address window and is acknowledged. A broadcast transfer carries, in the third phase, a bitmask of slot positions on address lines A21..A1. The slave takes part only when the bit for its own slot is set, and it stays silent on acknowledge because the master acknowledges itself. A configuration bit lets the slave refuse the fastest rate. A buffer-ready input decides whether an addressed slave must ask for a retry. A stalled strobe is caught by a timeout. All bus inputs are assumed to be already synchronised to `clk`.

Top module: `sst_rx_top`

## Requirements
- R1: A transfer is recognised only when `bus_am` equals 6'h20 at the first fall of `bus_ds0_n` while `bus_as_n` is low. Any other code gives no response and no writes until `bus_as_n` rises.
- R2: The phase-1 broadcast flag is `bus_data[0]`. The cycle count is `bus_data[CNT_W-1:0]` and the rate code is `bus_data[17:16]`, both latched on the rise of `bus_ds0_n` (phase 2).
- R3: Rate codes 0 (160), 1 (267) and 2 (320) are all accepted while `cfg_no320` is 0.
- R4: An addressed slave raises `berr_o` when the rate code is 3, or is 2 while `cfg_no320` is 1. It holds `berr_o` until `bus_as_n` rises and writes nothing.
- R5: Without broadcast, the slave is addressed only if `bus_addr[30:15]` (A31..A16) latched in phase 1 equals `cfg_base`. Otherwise it stays silent.
- R6: With broadcast, the slave takes part only if `cfg_geo`=g lies in 1..21 and `bus_addr[g-1]` (line Ag) is set at the phase-3 fall of `bus_ds0_n`. A slot value of 0 never takes part.
- R7: An addressed slave with no bus error whose `buf_ready` is low at phase 3 raises `retry_o` until `bus_as_n` rises and writes nothing. A bus error takes priority over retry.
- R8: A broadcast participant never drives `dtack_o`, yet it receives and writes the data.
- R9: An accepted point-to-point transfer with a nonzero count drives `dtack_o` from one clock after phase 3 until the last word. At most one of `dtack_o`, `berr_o` and `retry_o` is high.
- R10: In the data phase, each transition of `bus_ds1_n` writes one word on `wr_en_o`/`wr_data_o` one clock later. Word addresses run 0, 1, 2, …, and a transfer has exactly twice the cycle count in words.
- R11: `xfer_done_o` pulses for one clock together with the last word. A zero cycle count completes with that pulse one clock after phase 3, with no `dtack_o` and no writes.
- R12: If `TMO_CYC` clocks pass in the data phase with no `bus_ds1_n` transition, `tmo_err_o` is set, the slave returns to idle and no `xfer_done_o` pulse occurs. The next accepted transfer clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Data strobe 0, paces the address phases |
| bus_ds1_n | input | 1 | Data strobe 1, each transition carries a word |
| bus_am | input | 6 | Address modifier |
| bus_addr | input | ADDR_W (31) | Address lines A31..A1, index i is line A(i+1) |
| bus_data | input | DATA_W (32) | Data lines |
| cfg_base | input | ADDR_W-WIN_LSB (16) | Window base compared with A31..A16 |
| cfg_geo | input | GEO_W (5) | Own slot number |
| cfg_no320 | input | 1 | Refuse the fastest rate code |
| buf_ready | input | 1 | Local buffer can take a full transfer |
| dtack_o | output | 1 | Acknowledge drive request |
| berr_o | output | 1 | Bus error drive request |
| retry_o | output | 1 | Retry drive request |
| wr_en_o | output | 1 | Local write strobe |
| wr_addr_o | output | CNT_W+1 (9) | Local word address |
| wr_data_o | output | DATA_W (32) | Local write data |
| xfer_done_o | output | 1 | Transfer completed pulse |
| tmo_err_o | output | 1 | Sticky strobe-timeout error |

## Verification
The bench goes through every combination of cycle count 0..3, all four rate codes, the refuse-fastest bit, broadcast and buffer readiness. The cases it targets are these. A design that compared the rate against the wrong code would accept a refused rate or reject a legal one. A design that ranked retry above the bus error would ask for a restart of a transfer that can never succeed. A design that counted only one strobe edge per cycle would write half the words and never pulse completion. A slot sweep over 0..23 against a fixed mask catches an off-by-one in the A21..A1 mapping, and it catches a slot 0 taking part. A stalled strobe shows whether the timeout ends the transfer with no completion pulse and whether the next transfer clears the error.

// File: rtl/sst_rx_pkg.sv
package sst_rx_pkg;
  // Phase-1 address modifier that marks a double-edge transfer
  localparam logic [5:0] AM_SST    = 6'h20;
  // Phase-2 position of the rate field on the data lines
  localparam int         RATE_LSB  = 16;
  // Phase-1 data bit that selects broadcast
  localparam int         BCAST_BIT = 0;
  // Highest slot addressable on lines A21..A1
  localparam int         MAX_SLOT  = 21;

  typedef enum logic [1:0] {
    RATE_160 = 2'd0,
    RATE_267 = 2'd1,
    RATE_320 = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PH1  = 3'd1,
    ST_PH2  = 3'd2,
    ST_DATA = 3'd3,
    ST_HOLD = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_ACCEPT = 2'd1,
    RSP_BERR   = 2'd2,
    RSP_RETRY  = 2'd3
  } resp_e;
endpackage

// File: rtl/sst_rx_rstsync.sv
module sst_rx_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sst_rx_edge.sv
module sst_rx_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] tog_o
);
  logic [N-1:0] prev_q;

  // strobes idle high, so the history resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sig_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fall_o[i] =  prev_q[i] & ~sig_i[i];
    assign rise_o[i] = ~prev_q[i] &  sig_i[i];
    assign tog_o[i]  =  prev_q[i] ^  sig_i[i];
  end
endmodule

// File: rtl/sst_rx_decide.sv
module sst_rx_decide
  import sst_rx_pkg::*;
#(
  parameter int ADDR_W  = 31,
  parameter int WIN_LSB = 15,
  parameter int GEO_W   = 5,
  localparam int BASE_W = ADDR_W - WIN_LSB
) (
  input  logic              bcast_i,
  input  logic [ADDR_W-1:0] addr_p1_i,
  input  logic [ADDR_W-1:0] addr_p3_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [GEO_W-1:0]  cfg_geo_i,
  input  rate_e             rate_i,
  input  logic              cfg_no320_i,
  input  logic              buf_ready_i,
  output resp_e             resp_o
);
  localparam int NSLOT = (ADDR_W < MAX_SLOT) ? ADDR_W : MAX_SLOT;

  logic [NSLOT-1:0] slot_hit;
  logic             window_hit;
  logic             selected;
  logic             rate_bad;

  // slot s+1 owns address line A(s+1), held at index s
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_hit[s] = (32'(cfg_geo_i) == s + 1) && addr_p3_i[s];
  end

  assign window_hit = (addr_p1_i[ADDR_W-1:WIN_LSB] == cfg_base_i);
  assign selected   = bcast_i ? (|slot_hit) : window_hit;
  assign rate_bad   = (rate_i == RATE_RSV) || ((rate_i == RATE_320) && cfg_no320_i);

  always_comb begin
    if (!selected)         resp_o = RSP_NONE;
    else if (rate_bad)     resp_o = RSP_BERR;
    else if (!buf_ready_i) resp_o = RSP_RETRY;
    else                   resp_o = RSP_ACCEPT;
  end
endmodule

// File: rtl/sst_rx_dcap.sv
module sst_rx_dcap #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 64,
  localparam int IDX_W  = CNT_W + 1,
  localparam int TMR_W  = $clog2(TMO_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              active_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              last_o,
  output logic              tmo_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [IDX_W-1:0]  rem_q, rem_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              wen_q, wen_d;
  logic [IDX_W-1:0]  wadr_q, wadr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;

  assign last_o = active_i && tog_i && (rem_q == IDX_W'(1));
  assign tmo_o  = active_i && !tog_i && (tmr_q == TMR_W'(TMO_CYC - 1));

  always_comb begin
    rem_d  = rem_q;
    idx_d  = idx_q;
    tmr_d  = tmr_q;
    wen_d  = 1'b0;
    wadr_d = wadr_q;
    wdat_d = wdat_q;
    if (load_i) begin
      rem_d = {cnt_i, 1'b0};          // two words per counted cycle
      idx_d = '0;
      tmr_d = '0;
    end else if (active_i) begin
      if (tog_i) begin
        wen_d  = 1'b1;
        wadr_d = idx_q;
        wdat_d = data_i;
        idx_d  = idx_q + IDX_W'(1);
        rem_d  = rem_q - IDX_W'(1);
        tmr_d  = '0;
      end else begin
        tmr_d  = tmr_q + TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      idx_q  <= '0;
      tmr_q  <= '0;
      wen_q  <= 1'b0;
      wadr_q <= '0;
      wdat_q <= '0;
    end else begin
      rem_q  <= rem_d;
      idx_q  <= idx_d;
      tmr_q  <= tmr_d;
      wen_q  <= wen_d;
      wadr_q <= wadr_d;
      wdat_q <= wdat_d;
    end
  end

  assign wr_en_o   = wen_q;
  assign wr_addr_o = wadr_q;
  assign wr_data_o = wdat_q;
endmodule

// File: rtl/sst_rx_top.sv
module sst_rx_top
  import sst_rx_pkg::*;
#(
  parameter int ADDR_W  = 31,
  parameter int WIN_LSB = 15,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int GEO_W   = 5,
  parameter int TMO_CYC = 64,
  localparam int BASE_W = ADDR_W - WIN_LSB,
  localparam int IDX_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_as_n,
  input  logic              bus_ds0_n,
  input  logic              bus_ds1_n,
  input  logic [5:0]        bus_am,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [GEO_W-1:0]  cfg_geo,
  input  logic              cfg_no320,
  input  logic              buf_ready,
  output logic              dtack_o,
  output logic              berr_o,
  output logic              retry_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              xfer_done_o,
  output logic              tmo_err_o
);
  logic rst_q;

  sst_rx_rstsync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_q));

  // ---- strobe edges: bit 0 = ds0, bit 1 = ds1 ----
  logic [1:0] s_fall, s_rise, s_tog;

  sst_rx_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_q),
    .sig_i({bus_ds1_n, bus_ds0_n}),
    .fall_o(s_fall), .rise_o(s_rise), .tog_o(s_tog)
  );

  // ---- state and captured header ----
  state_e            state_q, state_d;
  resp_e             resp_q, resp_d;
  logic              bcast_q, bcast_d;
  logic [ADDR_W-1:0] addr1_q, addr1_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  rate_e             rate_q, rate_d;
  logic              done_q, done_d;
  logic              terr_q, terr_d;

  resp_e dec_resp;
  logic  cap_load;
  logic  cap_last;
  logic  cap_tmo;

  sst_rx_decide #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .GEO_W(GEO_W)) u_dec (
    .bcast_i(bcast_q),
    .addr_p1_i(addr1_q),
    .addr_p3_i(bus_addr),
    .cfg_base_i(cfg_base),
    .cfg_geo_i(cfg_geo),
    .rate_i(rate_q),
    .cfg_no320_i(cfg_no320),
    .buf_ready_i(buf_ready),
    .resp_o(dec_resp)
  );

  always_comb begin
    state_d  = state_q;
    resp_d   = resp_q;
    bcast_d  = bcast_q;
    addr1_d  = addr1_q;
    cnt_d    = cnt_q;
    rate_d   = rate_q;
    done_d   = 1'b0;
    terr_d   = terr_q;
    cap_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        resp_d = RSP_NONE;
        if (!bus_as_n && s_fall[0]) begin
          addr1_d = bus_addr;
          bcast_d = bus_data[BCAST_BIT];
          state_d = (bus_am == AM_SST) ? ST_PH1 : ST_HOLD;
        end
      end
      ST_PH1: begin
        if (bus_as_n) begin
          state_d = ST_IDLE;
        end else if (s_rise[0]) begin
          cnt_d   = bus_data[CNT_W-1:0];
          rate_d  = rate_e'(bus_data[RATE_LSB +: 2]);
          state_d = ST_PH2;
        end
      end
      ST_PH2: begin
        if (bus_as_n) begin
          state_d = ST_IDLE;
        end else if (s_fall[0]) begin
          resp_d = dec_resp;
          if (dec_resp == RSP_ACCEPT) begin
            cap_load = 1'b1;
            terr_d   = 1'b0;
            if (cnt_q == '0) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_DATA;
            end
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_DATA: begin
        if (cap_last) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (cap_tmo) begin
          terr_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (bus_as_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      resp_q  <= RSP_NONE;
      bcast_q <= 1'b0;
      addr1_q <= '0;
      cnt_q   <= '0;
      rate_q  <= RATE_160;
      done_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      resp_q  <= resp_d;
      bcast_q <= bcast_d;
      addr1_q <= addr1_d;
      cnt_q   <= cnt_d;
      rate_q  <= rate_d;
      done_q  <= done_d;
      terr_q  <= terr_d;
    end
  end

  sst_rx_dcap #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_cap (
    .clk(clk), .rst_n(rst_q),
    .load_i(cap_load),
    .cnt_i(cnt_q),
    .active_i(state_q == ST_DATA),
    .tog_i(s_tog[1]),
    .data_i(bus_data),
    .last_o(cap_last),
    .tmo_o(cap_tmo),
    .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  // responses decoded from registered state only
  assign dtack_o     = (state_q == ST_DATA) && !bcast_q;
  assign berr_o      = (state_q == ST_HOLD) && (resp_q == RSP_BERR);
  assign retry_o     = (state_q == ST_HOLD) && (resp_q == RSP_RETRY);
  assign xfer_done_o = done_q;
  assign tmo_err_o   = terr_q;
endmodule

// File: rtl/sst_rx_chk.sv
module sst_rx_chk
  import sst_rx_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  bus_ds1_n,
  input logic  buf_ready,
  input logic  cfg_no320,
  input logic  dtack_o,
  input logic  berr_o,
  input logic  retry_o,
  input logic  wr_en_o,
  input logic  xfer_done_o,
  input logic  tmo_err_o,
  input logic  bcast_q,
  input rate_e rate_q
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dtack_o, berr_o, retry_o})); // R9

  AST_BERR_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_o) |-> ($past(rate_q) == RATE_RSV) || (($past(rate_q) == RATE_320) && $past(cfg_no320))); // R4

  AST_RETRY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_o) |-> !$past(buf_ready)); // R7

  AST_BCAST_NO_DTACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_o) |-> !$past(bcast_q)); // R8

  AST_WRITE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(bus_ds1_n) != $past(bus_ds1_n, 2))); // R10

  AST_NO_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_o || retry_o) |-> !wr_en_o); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_done_o); // R11

  AST_TMO_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> !xfer_done_o); // R12
endmodule

bind sst_rx_top sst_rx_chk u_chk (
  .clk(clk), .rst_n(rst_q),
  .bus_ds1_n(bus_ds1_n), .buf_ready(buf_ready), .cfg_no320(cfg_no320),
  .dtack_o(dtack_o), .berr_o(berr_o), .retry_o(retry_o),
  .wr_en_o(wr_en_o), .xfer_done_o(xfer_done_o), .tmo_err_o(tmo_err_o),
  .bcast_q(bcast_q), .rate_q(rate_q)
);

// File: tb/sim_sst_rx_top.sv
module sim_sst_rx_top;
  localparam int ADDR_W = 31, DATA_W = 32, CNT_W = 8, GEO_W = 5, TMO_CYC = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_as_n, bus_ds0_n, bus_ds1_n;
  logic [5:0]        bus_am;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic [15:0]       cfg_base;
  logic [GEO_W-1:0]  cfg_geo;
  logic              cfg_no320, buf_ready;
  logic              dtack_o, berr_o, retry_o, wr_en_o, xfer_done_o, tmo_err_o;
  logic [CNT_W:0]    wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] trial = 8'd0;

  always #4 clk = ~clk;   // 125 MHz

  sst_rx_top u0 (.*);

  localparam logic [15:0] BASE = 16'h1234;
  localparam logic [20:0] MASK = 21'h12A4C6;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 accept, 2 berr, 3 retry
  function automatic int exp_resp(input logic [5:0] am, input logic bc, input logic [ADDR_W-1:0] a1,
                                  input logic [ADDR_W-1:0] a3, input int rate, input logic ready);
    logic hit;
    if (am != 6'h20) return 0;
    if (bc) hit = (cfg_geo >= 1) && (cfg_geo <= 21) && a3[cfg_geo - 1];
    else    hit = (a1[30:15] == cfg_base);
    if (!hit) return 0;
    if (rate == 3 || (rate == 2 && cfg_no320)) return 2;
    if (!ready) return 3;
    return 1;
  endfunction

  function automatic logic [31:0] word(input int i);
    return 32'hC0DE0000 | (32'(trial) << 8) | 32'(i);
  endfunction

  task automatic xfer(input string tag, input logic [5:0] am, input logic bc, input logic [ADDR_W-1:0] a1,
                      input logic [ADDR_W-1:0] a3, input int cnt, input int rate, input logic ready);
    int r;
    trial++;
    r = exp_resp(am, bc, a1, a3, rate, ready);
    @(negedge clk);
    bus_am = am; bus_addr = a1; bus_data = 32'(bc); bus_as_n = 1'b0; bus_ds0_n = 1'b0;
    @(negedge clk);
    bus_data = (32'(rate) << 16) | 32'(cnt); bus_ds0_n = 1'b1;
    @(negedge clk);
    bus_addr = a3; buf_ready = ready; bus_ds0_n = 1'b0;
    @(negedge clk);
    chk({tag, " R9 dtack"}, dtack_o, (r == 1) && cnt > 0 && !bc);
    chk({tag, " R4 berr"}, berr_o, r == 2);
    chk({tag, " R7 retry"}, retry_o, r == 3);
    chk({tag, " R11 done zero count"}, xfer_done_o, (r == 1) && cnt == 0);
    if (r == 1 && cnt > 0) begin
      for (int i = 0; i < 2 * cnt; i++) begin
        bus_ds1_n = ~bus_ds1_n; bus_data = word(i);
        @(negedge clk);
        chk({tag, " R10 wr_en"}, wr_en_o, 1'b1);
        chk({tag, " R10 wr_addr"}, wr_addr_o, 64'(i));
        chk({tag, " R10 wr_data"}, wr_data_o, word(i));
        chk({tag, " R11 done"}, xfer_done_o, i == 2 * cnt - 1);
        chk({tag, " R8 R9 dtack data"}, dtack_o, !bc && (i != 2 * cnt - 1));
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        bus_ds1_n = ~bus_ds1_n; bus_data = word(i);
        @(negedge clk);
        chk({tag, " R1 R4 R7 no write"}, wr_en_o, 1'b0);
        chk({tag, " R4 R7 held"}, {berr_o, retry_o}, {r == 2, r == 3});
      end
    end
    bus_as_n = 1'b1; bus_ds0_n = 1'b1;
    @(negedge clk);
    chk({tag, " released"}, {dtack_o, berr_o, retry_o, wr_en_o}, 4'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a_hit, a_miss;
    a_hit  = {BASE, 15'h0};
    a_miss = {BASE + 16'd1, 15'h0};
    rst_n = 1'b0; bus_as_n = 1'b1; bus_ds0_n = 1'b1; bus_ds1_n = 1'b1;
    bus_am = 6'h0; bus_addr = '0; bus_data = '0;
    cfg_base = BASE; cfg_geo = 5'd3; cfg_no320 = 1'b0; buf_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("reset outputs", {dtack_o, berr_o, retry_o, wr_en_o, xfer_done_o, tmo_err_o}, 6'b0);

    // R2 R3 R4 R7 R8 R9 R10 R11: full sweep, slot 3 set in MASK
    for (int bc = 0; bc < 2; bc++)
      for (int no = 0; no < 2; no++)
        for (int rd = 0; rd < 2; rd++)
          for (int rate = 0; rate < 4; rate++)
            for (int cnt = 0; cnt < 4; cnt++) begin
              cfg_no320 = no[0];
              xfer("sweep R3", 6'h20, bc[0], a_hit, {10'h0, MASK}, cnt, rate, rd[0]);
            end
    cfg_no320 = 1'b0;

    // R1: other modifiers are ignored
    xfer("R1 am 21", 6'h21, 1'b0, a_hit, a_hit, 2, 0, 1'b1);
    xfer("R1 am 08", 6'h08, 1'b0, a_hit, a_hit, 2, 0, 1'b1);
    // R5: window miss
    xfer("R5 miss", 6'h20, 1'b0, a_miss, a_miss, 2, 0, 1'b1);
    xfer("R5 hit", 6'h20, 1'b0, a_hit, a_miss, 1, 1, 1'b1);
    // R6: slot sweep including 0 and out-of-range
    for (int g = 0; g < 24; g++) begin
      cfg_geo = 5'(g);
      xfer("R6 slot", 6'h20, 1'b1, a_miss, {10'h0, MASK}, 1, 1, 1'b1);
    end
    cfg_geo = 5'd3;

    // R12: stall after two words of a three-cycle transfer
    @(negedge clk);
    bus_am = 6'h20; bus_addr = a_hit; bus_data = 32'h0; bus_as_n = 1'b0; bus_ds0_n = 1'b0;
    @(negedge clk); bus_data = 32'd3; bus_ds0_n = 1'b1;
    @(negedge clk); bus_ds0_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      bus_ds1_n = ~bus_ds1_n;
      @(negedge clk);
    end
    begin
      int seen_done = 0;
      repeat (TMO_CYC + 4) begin
        @(negedge clk);
        if (xfer_done_o) seen_done++;
      end
      chk("R12 tmo_err set", tmo_err_o, 1'b1);
      chk("R12 no done", seen_done, 0);
      chk("R12 idle no dtack", dtack_o, 1'b0);
    end
    bus_as_n = 1'b1; bus_ds0_n = 1'b1;
    @(negedge clk);
    chk("R12 error sticky", tmo_err_o, 1'b1);
    xfer("R12 clear", 6'h20, 1'b0, a_hit, a_hit, 1, 0, 1'b1);
    chk("R12 cleared by accept", tmo_err_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule